// File: doc/BRIEF.md
# Edge-Strobed Watchdog Timer

This block watches a strobe line driven by a processor. Every change of level on the strobe, rising or falling, restarts a timeout count. If the strobe holds still for the whole timeout, the block drives its active-low status output low for a fixed number of ticks. It then starts counting again from zero. A processor that has stopped therefore produces a train of pulses, one per timeout period.

The timeout is set by a two-bit strapped select. The select follows its pins until counting is first enabled and is then frozen until the next reset. Counting waits for a flag that shows at least one system reset output has been released. While that flag is low, the counter is held at zero and the status output stays high. Time advances only on cycles where the tick enable is high, so one prescaled tick can drive many instances. The watchdog has no disable input.

Top module: `strobe_watchdog`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, wdt_no is high.
- R2: While run_i is low, the counter is held at zero, wdt_no is high from the next cycle on, and strobe changes have no effect on later timing.
- R3: The select code sets the timeout in ticks: 2'b00 gives TICKS_SHORT, 2'b01 gives TICKS_MID, and 2'b10 or 2'b11 gives TICKS_LONG. With a tick on every cycle and no strobe change, wdt_no is first seen low timeout+1 cycles after run_i is driven high.
- R4: sel_i is sampled on every clock until the first clock at which run_i is high. After that it is frozen until the next reset.
- R5: Any strobe level held for at least one clock period is detected. Both a rising and a falling change clear the count at the third rising clock edge after the change, so timeout expires TIMEOUT ticks after that edge.
- R6: On timeout, wdt_no goes low for exactly PULSE_TICKS ticks. Strobe changes during the pulse neither shorten nor extend it.
- R7: After a pulse ends, the count restarts from zero. If the strobe stays still, wdt_no is high for exactly TIMEOUT ticks between pulses.
- R8: Only cycles with tick_i high advance the counter. With tick_i held low, no timeout occurs.
- R9: Dropping run_i during a pulse returns wdt_no high on the next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Asynchronous strobe from the processor |
| sel_i | input | 2 | Strapped timeout select |
| run_i | input | 1 | High once any system reset output is inactive |
| tick_i | input | 1 | Time-base enable, one cycle per tick |
| wdt_no | output | 1 | Active-low timeout status pulse |

## Verification
Inputs are driven at the falling clock edge and results are sampled at the same point. The counter starts at the rising edge after run_i goes high, so with a tick on every cycle the first low sample falls timeout+1 cycles after run_i is driven. A strobe change passes two synchronizer flops and the edge register before it clears the count, so a restart is expected timeout+3 cycles after the change. Pulse width and the gap between pulses are counted in whole samples and must equal PULSE_TICKS and the timeout exactly. Checks that something is ignored, such as gating, held ticks and strobes during a pulse, watch wdt_no over windows longer than a full timeout.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    WD_IDLE  = 2'b00,
    WD_COUNT = 2'b01,
    WD_PULSE = 2'b10
  } wd_state_e;

  localparam logic [1:0] TSEL_SHORT = 2'b00;
  localparam logic [1:0] TSEL_MID   = 2'b01;
  localparam logic [1:0] TSEL_LONG  = 2'b10;
endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_i,
  output logic edge_o
);
  // chain[SYNC_STAGES-1] is the synchronized level, chain[SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[SYNC_STAGES-1:0], strobe_i};
  end

  assign edge_o = chain_q[SYNC_STAGES] ^ chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/wdt_sel_latch.sv
module wdt_sel_latch
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int TICKS_SHORT = 16,
  parameter int TICKS_MID   = 160,
  parameter int TICKS_LONG  = 200
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [1:0]       sel_i,
  output logic [CNT_W-1:0] limit_o
);
  logic       armed_q;
  logic [1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      sel_q   <= TSEL_LONG;
    end else if (!armed_q) begin
      sel_q   <= sel_i;
      armed_q <= run_i;
    end
  end

  always_comb begin
    unique case (sel_q)
      TSEL_SHORT: limit_o = CNT_W'(TICKS_SHORT);
      TSEL_MID:   limit_o = CNT_W'(TICKS_MID);
      default:    limit_o = CNT_W'(TICKS_LONG);
    endcase
  end

  // R4
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(armed_q)) |-> $stable(sel_q));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int PULSE_TICKS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wdt_no
);
  localparam logic [CNT_W-1:0] PulseLast = CNT_W'(PULSE_TICKS - 1);

  wd_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else if (!run_i) begin
      state_q <= WD_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        WD_IDLE: begin
          state_q <= WD_COUNT;
          cnt_q   <= '0;
        end
        WD_COUNT: begin
          if (edge_i) cnt_q <= '0;
          else if (tick_i) begin
            if (cnt_q == limit_i - 1'b1) begin
              state_q <= WD_PULSE;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        WD_PULSE: begin
          // strobe edges ignored: fixed pulse width
          if (tick_i) begin
            if (cnt_q == PulseLast) begin
              state_q <= WD_COUNT;
              cnt_q   <= '0;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: begin
          state_q <= WD_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  assign wdt_no = (state_q != WD_PULSE);

  // R2
  run_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (wdt_no && cnt_q == '0));
  // R5
  restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && state_q == WD_COUNT && edge_i) |=> (cnt_q == '0 && wdt_no));
  // R8
  tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_i && !edge_i) |=> $stable(cnt_q));
  // R3
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WD_COUNT) |-> (cnt_q < limit_i));
endmodule

// File: rtl/strobe_watchdog.sv
module strobe_watchdog #(
  parameter int TICKS_SHORT = 16000,
  parameter int TICKS_MID   = 160000,
  parameter int TICKS_LONG  = 1600000,
  parameter int PULSE_TICKS = 100,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       strobe_i,
  input  logic [1:0] sel_i,
  input  logic       run_i,
  input  logic       tick_i,
  output logic       wdt_no
);
  localparam int MaxTicks = (TICKS_LONG > PULSE_TICKS) ? TICKS_LONG : PULSE_TICKS;
  localparam int CntW     = $clog2(MaxTicks + 1);

  logic            edge_s;
  logic [CntW-1:0] limit_s;

  wdt_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_i),
    .edge_o   (edge_s)
  );

  wdt_sel_latch #(
    .CNT_W       (CntW),
    .TICKS_SHORT (TICKS_SHORT),
    .TICKS_MID   (TICKS_MID),
    .TICKS_LONG  (TICKS_LONG)
  ) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .sel_i   (sel_i),
    .limit_o (limit_s)
  );

  wdt_timer #(
    .CNT_W       (CntW),
    .PULSE_TICKS (PULSE_TICKS)
  ) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_i),
    .tick_i  (tick_i),
    .edge_i  (edge_s),
    .limit_i (limit_s),
    .wdt_no  (wdt_no)
  );
endmodule

// File: tb/strobe_watchdog_tb_top.sv
module strobe_watchdog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int T_S = 6;
  localparam int T_M = 12;
  localparam int T_L = 20;
  localparam int P   = 3;

  localparam logic [1:0] SEL_TAB [4] = '{2'b00, 2'b01, 2'b10, 2'b11};
  localparam int         LIM_TAB [4] = '{T_S, T_M, T_L, T_L};

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       strobe = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       run = 1'b0;
  logic       tick = 1'b1;
  logic       wdt_no;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_watchdog #(
    .TICKS_SHORT (T_S),
    .TICKS_MID   (T_M),
    .TICKS_LONG  (T_L),
    .PULSE_TICKS (P)
  ) dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .sel_i    (sel),
    .run_i    (run),
    .tick_i   (tick),
    .wdt_no   (wdt_no)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; run = 1'b0; tick = 1'b1;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  // negedges until wdt_no seen low (includes the low sample)
  task automatic count_to_low(output int k);
    k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (wdt_no && k < 400);
  endtask

  task automatic count_while(input logic lvl, output int k);
    k = 0;
    while (wdt_no == lvl && k < 400) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic watch_high(input int cycles, output int lows);
    lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!wdt_no) lows++;
    end
  endtask

  initial begin
    int k, h, lows;
    // R1: reset state
    rst_ni = 1'b0;
    #(CLK_PERIOD*2 + 1);
    check(wdt_no == 1'b1, "R1 in reset", wdt_no, 1);
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(wdt_no == 1'b1, "R1 after release", wdt_no, 1);

    // R3/R6/R7 table walk
    for (int i = 0; i < 4; i++) begin
      do_reset();
      sel = SEL_TAB[i];
      @(negedge clk);
      run = 1'b1;
      count_to_low(k);
      check(k == LIM_TAB[i] + 1, "R3 timeout", k, LIM_TAB[i] + 1);
      strobe = ~strobe;  // R6: change during pulse ignored
      k = 1;
      @(negedge clk);
      count_while(1'b0, h);
      k += h;
      check(k == P, "R6 pulse width", k, P);
      count_while(1'b1, h);
      check(h == LIM_TAB[i], "R7 gap between pulses", h, LIM_TAB[i]);
    end

    // R2: gated, strobes ignored, count held at zero
    do_reset();
    sel = 2'b00;
    for (int i = 0; i < 3 * T_S; i++) begin
      @(negedge clk);
      if (i % 2 == 0) strobe = ~strobe;
      if (!wdt_no) lows++;
    end
    check(lows == 0, "R2 no pulse while gated", lows, 0);
    repeat (4) @(negedge clk);
    run = 1'b1;
    count_to_low(k);
    check(k == T_S + 1, "R2 count starts from zero", k, T_S + 1);

    // R5: rising change restarts
    do_reset();
    sel = 2'b00; strobe = 1'b0;
    repeat (4) @(negedge clk);
    run = 1'b1;
    repeat (T_S - 3) @(negedge clk);
    strobe = 1'b1;
    count_to_low(k);
    check(k == T_S + 3, "R5 rising restart", k, T_S + 3);

    // R5: falling change restarts
    do_reset();
    sel = 2'b00;
    repeat (4) @(negedge clk);
    run = 1'b1;
    repeat (T_S - 3) @(negedge clk);
    strobe = 1'b0;
    count_to_low(k);
    check(k == T_S + 3, "R5 falling restart", k, T_S + 3);

    // R5: periodic strobing keeps it quiet
    do_reset();
    sel = 2'b00;
    @(negedge clk);
    run = 1'b1;
    lows = 0;
    for (int i = 0; i < 6 * T_S; i++) begin
      @(negedge clk);
      if (i % (T_S - 2) == 0) strobe = ~strobe;
      if (!wdt_no) lows++;
    end
    check(lows == 0, "R5 keep-alive", lows, 0);

    // R4: select frozen after first enable
    do_reset();
    sel = 2'b00;
    @(negedge clk);
    sel = 2'b10;
    run = 1'b1;
    repeat (2) @(negedge clk);
    sel = 2'b00;
    count_to_low(k);
    check(k == T_L - 1, "R4 select frozen", k, T_L - 1);

    // R8: no ticks, no timeout
    do_reset();
    sel = 2'b00;
    tick = 1'b0;
    @(negedge clk);
    run = 1'b1;
    watch_high(4 * T_S, lows);
    check(lows == 0, "R8 held ticks", lows, 0);
    // R8: half-rate ticks double the timeout
    do_reset();
    sel = 2'b00;
    @(negedge clk);
    run = 1'b1;
    k = 0;
    do begin
      tick = ~tick;
      @(negedge clk);
      k++;
    end while (wdt_no && k < 400);
    check(k >= 2 * T_S && k <= 2 * T_S + 3, "R8 half-rate timeout", k, 2 * T_S + 1);

    // R9: drop run during pulse
    do_reset();
    sel = 2'b00;
    @(negedge clk);
    run = 1'b1;
    count_to_low(k);
    run = 1'b0;
    @(negedge clk);
    check(wdt_no == 1'b1, "R9 release on gate drop", wdt_no, 1);
    watch_high(3 * T_S, lows);
    check(lows == 0, "R9 stays high", lows, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule